// File: doc/BRIEF.md
# Three-Input Boolean and Split-Lane Arithmetic Unit

This block is the data-unit datapath of a pixel-oriented processor. Its three-input logic stage can produce any of the 256 boolean functions of three operand bits: an 8-bit code serves as the truth table and is applied to every bit position. The same unit adds or subtracts either as one 32-bit word or as four independent byte lanes, which gives four results per cycle on packed pixels. It also builds a low-order mask of ones from a count.

Two conditional features shape the result. A source-select enable lets a status flag choose the second arithmetic operand. A write gate lets a condition suppress the update, in which case the output register keeps its old value. Everything is combinational up to a single output register. A decoder upstream drives the mode, lane size and operands directly.

Top module: `pix_alu_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `carry` and `res_valid` are all zero.
- R2: With `mode`=0 (boolean), bit i of `result` equals bit {opa[i],opb[i],opc[i]} of `func`, where opa supplies the most significant of the three index bits.
- R3: With `lane_byte`=0, `mode`=1 gives opa+Q modulo 2^32 and `mode`=2 gives opa-Q modulo 2^32. `carry[3]` is the carry out of bit 31, which for subtraction is 1 when no borrow occurs. `carry[2:0]` are 0.
- R4: With `lane_byte`=1, each byte lane k (bits 8k+7..8k) adds or subtracts on its own with no carry from the lane below. `carry[k]` is that lane's carry out, or for subtraction its no-borrow flag.
- R5: With `mode`=3 (mask), a count n in 1..31 yields a word whose n low bits are ones and whose other bits are zeros. A count of 0 yields zero, and any count of 32 or more yields all ones.
- R6: In modes 1 and 2 the second operand Q is `opb` when `src_sel` is 0. When `src_sel` is 1, Q is `opb` if `flag` is 1 and `opc` if `flag` is 0.
- R7: An update takes place only when `in_valid` is 1 and either `gate_en` is 0 or `gate_ok` is 1. Otherwise, on the next edge, `res_valid` drops to 0 and `result` and `carry` keep their previous values.
- R8: An accepted operation shows its result, its carry and `res_valid`=1 one clock edge after it is presented.
- R9: In modes 0 and 3, `carry` is zero after an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opc | input | 32 | Operand C |
| func | input | 8 | Boolean truth-table code |
| mode | input | 2 | 0 boolean, 1 add, 2 subtract, 3 mask |
| lane_byte | input | 1 | 1 selects four byte lanes, 0 one 32-bit word |
| mask_cnt | input | 6 | Number of low one-bits for mask mode |
| src_sel | input | 1 | Enables flag-driven choice of second operand |
| flag | input | 1 | Status flag for operand choice |
| gate_en | input | 1 | Makes the write conditional |
| gate_ok | input | 1 | Condition for a conditional write |
| result | output | 32 | Registered result |
| carry | output | 4 | Registered per-lane carry flags |
| res_valid | output | 1 | Result was updated on the last edge |

## Verification
Every result, carry flag and valid bit is due exactly one rising edge after the inputs that produce it are applied, because the only register is the output stage. The bench applies inputs shortly after an edge and lets its reference model advance on the following edge. It then compares `result`, `carry` and `res_valid` one nanosecond after that edge, so each comparison covers exactly one stimulus. For gated or idle cycles the model keeps its previous expected result and carry, so a hold is checked in the same cycle slot as an update.

// File: rtl/pix_alu_pkg.sv
`timescale 1ns/1ps
package pix_alu_pkg;
  typedef enum logic [1:0] {
    OP_BOOL = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_MASK = 2'd3
  } alu_op_e;

  // Second arithmetic operand: flag picks between B and C when enabled.
  function automatic logic [31:0] pick_second(input logic en, input logic flg,
                                              input logic [31:0] b,
                                              input logic [31:0] c);
    pick_second = (en && !flg) ? c : b;
  endfunction
endpackage

// File: rtl/pix_tt_logic.sv
`timescale 1ns/1ps
module pix_tt_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  input  logic [7:0]        code,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y[i] = code[{a[i], b[i], c[i]}];
  end
endmodule

// File: rtl/pix_lane_addsub.sv
`timescale 1ns/1ps
module pix_lane_addsub #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]        p,
  input  logic [DATA_W-1:0]        q,
  input  logic                     sub,
  input  logic                     split,
  output logic [DATA_W-1:0]        sum,
  output logic [DATA_W/LANE_W-1:0] cflags
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] cin;
  logic [LANES-1:0] cout;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W:0] part;
    if (k == 0) begin : g_first
      assign cin[k] = sub;
    end else begin : g_rest
      assign cin[k] = split ? sub : cout[k-1];
    end
    assign part = {1'b0, p[k*LANE_W +: LANE_W]}
                + {1'b0, q[k*LANE_W +: LANE_W] ^ {LANE_W{sub}}}
                + {{LANE_W{1'b0}}, cin[k]};
    assign sum[k*LANE_W +: LANE_W] = part[LANE_W-1:0];
    assign cout[k] = part[LANE_W];
  end

  assign cflags = split ? cout : {cout[LANES-1], {(LANES-1){1'b0}}};
endmodule

// File: rtl/pix_mask_gen.sv
`timescale 1ns/1ps
module pix_mask_gen #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] mask
);
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (int'(cnt) > i);
    end
  end
endmodule

// File: rtl/pix_alu_unit.sv
`timescale 1ns/1ps
module pix_alu_unit
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        opa,
  input  logic [DATA_W-1:0]        opb,
  input  logic [DATA_W-1:0]        opc,
  input  logic [7:0]               func,
  input  logic [1:0]               mode,
  input  logic                     lane_byte,
  input  logic [CNT_W-1:0]         mask_cnt,
  input  logic                     src_sel,
  input  logic                     flag,
  input  logic                     gate_en,
  input  logic                     gate_ok,
  output logic [DATA_W-1:0]        result,
  output logic [DATA_W/LANE_W-1:0] carry,
  output logic                     res_valid
);
  localparam int LANES = DATA_W / LANE_W;

  alu_op_e            op;
  logic [DATA_W-1:0]  second_op;
  logic [DATA_W-1:0]  tt_y;
  logic [DATA_W-1:0]  as_y;
  logic [LANES-1:0]   as_c;
  logic [DATA_W-1:0]  mk_y;
  logic [DATA_W-1:0]  next_res;
  logic [LANES-1:0]   next_car;
  logic               commit;
  logic               is_arith;

  assign op        = alu_op_e'(mode);
  assign is_arith  = (op == OP_ADD) || (op == OP_SUB);
  assign second_op = pick_second(src_sel, flag, opb, opc);
  assign commit    = in_valid && (!gate_en || gate_ok);

  pix_tt_logic #(.DATA_W(DATA_W)) i_tt (
    .a(opa), .b(opb), .c(opc), .code(func), .y(tt_y)
  );

  pix_lane_addsub #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_as (
    .p(opa), .q(second_op), .sub(op == OP_SUB), .split(lane_byte),
    .sum(as_y), .cflags(as_c)
  );

  pix_mask_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_mk (
    .cnt(mask_cnt), .mask(mk_y)
  );

  always_comb begin
    unique case (op)
      OP_BOOL: next_res = tt_y;
      OP_ADD,
      OP_SUB:  next_res = as_y;
      default: next_res = mk_y;
    endcase
    next_car = is_arith ? as_c : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      carry     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= commit;
      if (commit) begin
        result <= next_res;
        carry  <= next_car;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (result == '0) && (carry == '0) && !res_valid); // R1
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (!gate_en || gate_ok)) |=> !res_valid && $stable(result) && $stable(carry)); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!gate_en || gate_ok)) |=> res_valid); // R8
  AST_WORD_LOW_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !lane_byte) |=> (carry[LANES-2:0] == '0)); // R3
  AST_TT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_BOOL && func == 8'hFF) |=> (result == '1)); // R2
  AST_MASK_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_MASK && int'(mask_cnt) >= DATA_W) |=> (result == '1)); // R5
  AST_NO_CARRY_NONARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !is_arith) |=> (carry == '0)); // R9
endmodule

// File: tb/test_pix_alu_unit.sv
`timescale 1ns/1ps
module test_pix_alu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0, opc = '0;
  logic [7:0]  func = '0;
  logic [1:0]  mode = '0;
  logic        lane_byte = 1'b0;
  logic [5:0]  mask_cnt = '0;
  logic        src_sel = 1'b0, flag = 1'b0, gate_en = 1'b0, gate_ok = 1'b0;
  logic [31:0] result;
  logic [3:0]  carry;
  logic        res_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit [31:0] exp_res = '0;
  bit [3:0]  exp_car = '0;
  bit        exp_val = 1'b0;

  always #2 clk = ~clk;

  pix_alu_unit i_pix_alu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .opc(opc), .func(func), .mode(mode), .lane_byte(lane_byte),
    .mask_cnt(mask_cnt), .src_sel(src_sel), .flag(flag), .gate_en(gate_en),
    .gate_ok(gate_ok), .result(result), .carry(carry), .res_valid(res_valid)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: evaluated from the requirements, one op at a time.
  task automatic model();
    bit [31:0] q;
    bit [31:0] r;
    bit [3:0]  cf;
    longint    acc;
    if (!(in_valid && (!gate_en || gate_ok))) begin
      exp_val = 1'b0;
      return;
    end
    q  = (src_sel && !flag) ? opc : opb;
    r  = '0;
    cf = '0;
    case (mode)
      2'd0: for (int i = 0; i < 32; i++)
              r[i] = func[opa[i]*4 + opb[i]*2 + opc[i]];
      2'd3: r = (mask_cnt >= 32) ? 32'hFFFF_FFFF
                                 : 32'((64'd1 << mask_cnt) - 1);
      default: begin
        if (lane_byte) begin
          for (int k = 0; k < 4; k++) begin
            int x = int'(opa[8*k +: 8]);
            int y = int'(q[8*k +: 8]);
            int s = (mode == 2'd1) ? x + y : x + 256 - y;
            r[8*k +: 8] = 8'(s);
            cf[k] = (s >= 256);
          end
        end else begin
          acc = (mode == 2'd1) ? longint'(opa) + longint'(q)
                               : longint'(opa) + 64'h1_0000_0000 - longint'(q);
          r = acc[31:0];
          cf[3] = acc[32];
        end
      end
    endcase
    exp_res = r;
    exp_car = cf;
    exp_val = 1'b1;
  endtask

  task automatic tick(input string tag);
    model();
    @(posedge clk);
    #1;
    check(tag, "result", result, exp_res);
    check(tag, "carry", carry, exp_car);
    check(tag, "valid", res_valid, exp_val);
  endtask

  task automatic setop(input bit [1:0] m, input bit lb, input bit [31:0] a,
                       input bit [31:0] b, input bit [31:0] c, input bit [7:0] f,
                       input bit [5:0] n);
    in_valid = 1'b1; mode = m; lane_byte = lb; opa = a; opb = b; opc = c;
    func = f; mask_cnt = n; src_sel = 1'b0; flag = 1'b0;
    gate_en = 1'b0; gate_ok = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "result", result, 0);
    check("R1", "carry", carry, 0);
    check("R1", "valid", res_valid, 0);
    rst_n = 1'b1;

    // R2 boolean truth tables
    setop(0, 0, 32'hF0F0_CC33, 32'hCCCC_AA55, 32'hAAAA_0F0F, 8'hE8, 0); tick("R2");
    setop(0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0, 8'h96, 0); tick("R2");
    setop(0, 0, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'hFFFF_0000, 8'hCA, 0); tick("R2");
    setop(0, 1, 32'h5555_5555, 32'h0, 32'h0, 8'hFF, 0); tick("R9");
    setop(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00, 0); tick("R2");
    // R3 word arithmetic
    setop(1, 0, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0); tick("R3");
    setop(1, 0, 32'h00FF_00FF, 32'h0001_0001, 32'h0, 0, 0); tick("R3");
    setop(2, 0, 32'h1, 32'h2, 32'h0, 0, 0); tick("R3");
    setop(2, 0, 32'h100, 32'hFF, 32'h0, 0, 0); tick("R3");
    // R4 byte lanes
    setop(1, 1, 32'h80FF_7F01, 32'h8001_7F01, 32'h0, 0, 0); tick("R4");
    setop(2, 1, 32'h0010_FF05, 32'h0110_0106, 32'h0, 0, 0); tick("R4");
    setop(1, 1, 32'hFFFF_FFFF, 32'h0101_0101, 32'h0, 0, 0); tick("R4");
    // R5 mask counts
    setop(3, 0, 0, 0, 0, 0, 7);  tick("R5");
    setop(3, 0, 0, 0, 0, 0, 0);  tick("R5");
    setop(3, 0, 0, 0, 0, 0, 31); tick("R5");
    setop(3, 0, 0, 0, 0, 0, 32); tick("R5");
    setop(3, 0, 0, 0, 0, 0, 63); tick("R5");
    setop(3, 0, 0, 0, 0, 0, 1);  tick("R5");
    // R6 flag-driven operand choice
    setop(1, 0, 32'h100, 32'h5, 32'h70, 0, 0); src_sel = 1; flag = 1; tick("R6");
    setop(1, 0, 32'h100, 32'h5, 32'h70, 0, 0); src_sel = 1; flag = 0; tick("R6");
    setop(2, 1, 32'h1010_1010, 32'h0101_0101, 32'h2020_2020, 0, 0);
    src_sel = 1; flag = 0; tick("R6");
    // R7 gated and idle cycles hold
    setop(1, 0, 32'h7, 32'h8, 0, 0, 0); tick("R8");
    setop(0, 0, 32'hFFFF_FFFF, 0, 0, 8'hFF, 0); gate_en = 1; gate_ok = 0; tick("R7");
    in_valid = 1'b0; tick("R7");
    setop(3, 0, 0, 0, 0, 0, 12); gate_en = 1; gate_ok = 1; tick("R7");
    // mixed traffic
    for (int t = 0; t < 300; t++) begin
      setop(2'($urandom), 1'($urandom), $urandom, $urandom, $urandom,
            8'($urandom), 6'($urandom));
      src_sel = 1'($urandom); flag = 1'($urandom);
      gate_en = 1'($urandom); gate_ok = 1'($urandom);
      in_valid = ($urandom % 8) != 0;
      tick("R8");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule